// File: doc/BRIEF.md
# NOR Flash Command Sequencer

This block sits between a host and a 16-bit NOR flash array and carries out the multi-cycle command protocols that such an array needs. The host asks for one of four operations: program a word, erase a sector, suspend an erase, or resume an erase. The sequencer issues the unlock and command write cycles back to back. It then reads the status bit (bit 7 of the read word) until the operation has finished, and reports the result with a one-cycle done or reject pulse.

The flash side is a plain synchronous word bus. A read strobe returns its word on the cycle after the strobe. A write strobe carries address and data in the same cycle. Before a program, the sequencer reads the target word and refuses any request that would need a 0 bit to become 1. After an erase has been issued, the host stays free. The sequencer keeps polling the sector in the background, and an erase suspend can be requested during that time. The current mode (read, write, erase, erase-suspended) is always visible on `state_o`.

Top module: `nor_cmd_seq`

## Requirements
- R1: After reset, `state_o` is 0 (read mode) and `busy`, `done`, `reject`, `fl_we` and `fl_re` are all low. The mode codes are read=0, write=1, erase=2 and erase-suspended=3. The operation codes on `op_code` are program=0, erase=1, suspend=2 and resume=3.
- R2: A program issues four write cycles in consecutive cycles: 0x00AA at word 0x555, then 0x0055 at 0x2AA, then 0x00A0 at 0x555, then the data word at the target address. `state_o` is 1 while these cycles run.
- R3: Before any write, a program reads the target word (old). If (~old & new) is nonzero, the request is rejected with no write cycle and the mode stays read.
- R4: After its writes, a program reads the target until bit 7 of the read word equals bit 7 of the data. It then pulses `done` and returns to mode 0.
- R5: An erase issues six consecutive write cycles: 0xAA@0x555, 0x55@0x2AA, 0x80@0x555, 0xAA@0x555, 0x55@0x2AA, then 0x30 at the sector address. `state_o` is 2 from the cycle after acceptance.
- R6: While in erase mode and idle, the sector address is polled in the background. A read with bit 7 = 1 pulses `done` and returns the mode to 0.
- R7: A suspend first reads the sector. If bit 7 is already 1, it sends no write cycle, pulses `done` and returns to mode 0.
- R8: Otherwise, the suspend writes 0x00B0 to the sector address and polls until bit 7 is 1. It then pulses `done` and enters mode 3.
- R9: A resume writes 0x0030 to the sector address and returns to mode 2. Completion then follows R6.
- R10: Program and erase are accepted only in mode 0, suspend only in mode 2, and resume only in mode 3. Any other request is answered by `reject` in the next cycle, with no bus cycle and no change of mode.
- R11: `busy` is high for the whole of a sequence. A request presented while `busy` is high is ignored: it causes no reject and no extra write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Request strobe, taken when busy is low |
| op_code | input | 2 | Operation: 0 program, 1 erase, 2 suspend, 3 resume |
| op_addr | input | AW | Target word address or sector base address |
| op_data | input | DW | Program data |
| busy | output | 1 | Sequence in progress; requests ignored |
| done | output | 1 | One-cycle pulse when an operation finishes |
| reject | output | 1 | One-cycle pulse when a request is refused |
| state_o | output | 2 | Mode: 0 read, 1 write, 2 erase, 3 erase-suspended |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | DW | Flash write data |
| fl_we | output | 1 | Flash write strobe |
| fl_re | output | 1 | Flash read strobe; data returns next cycle |
| fl_rdata | input | DW | Flash read data |

## Verification
The bench names the acceptance edge cycle 0 and counts cycles from it. Each result is due at a fixed count:
- A mode-order reject is due in cycle 1, and a bit-conflict reject in cycle 3.
- With P status reads needed, `done` is due in cycle 7+2P for a program or an erase, 4+2P for a suspend and 2+2P for a resume.
- A suspend that finds the erase already finished is done in cycle 3.
- The mode changes to 1 by cycle 3 of a program and to 2 by cycle 1 of an erase or cycle 2 of a resume.

The bench samples every output on the falling edge and compares the cycle of the first `done` or `reject` pulse with these counts. Its flash model serves a scripted list of read words and records every write cycle, so the write sequences and their count are compared after each operation.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [1:0] {
    OP_PROG  = 2'd0,
    OP_ERASE = 2'd1,
    OP_SUSP  = 2'd2,
    OP_RES   = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    MD_READ  = 2'd0,
    MD_WRITE = 2'd1,
    MD_ERASE = 2'd2,
    MD_ESUSP = 2'd3
  } md_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_PRE_RD,
    PH_PRE_EV,
    PH_CMD,
    PH_POLL_RD,
    PH_POLL_EV
  } ph_e;

  localparam logic [7:0] CB_UNLOCK1 = 8'hAA;
  localparam logic [7:0] CB_UNLOCK2 = 8'h55;
  localparam logic [7:0] CB_PROG    = 8'hA0;
  localparam logic [7:0] CB_ERASE   = 8'h80;
  localparam logic [7:0] CB_SECTOR  = 8'h30;
  localparam logic [7:0] CB_SUSP    = 8'hB0;

  // Mode-order rule: which requests a mode may take
  function automatic logic op_allowed(op_e op, md_e md);
    case (op)
      OP_PROG, OP_ERASE: return md == MD_READ;
      OP_SUSP:           return md == MD_ERASE;
      default:           return md == MD_ESUSP;
    endcase
  endfunction

endpackage

// File: rtl/nor_seq_cmdgen.sv
module nor_seq_cmdgen
  import nor_seq_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 16,
  parameter int STW = 3,
  parameter logic [AW-1:0] UNLOCK_A1 = 'h555,
  parameter logic [AW-1:0] UNLOCK_A2 = 'h2AA
) (
  input  op_e              op,
  input  logic [STW-1:0]   step,
  input  logic [AW-1:0]    tgt,
  input  logic [DW-1:0]    data,
  output logic [AW-1:0]    cyc_addr,
  output logic [DW-1:0]    cyc_data,
  output logic             cyc_last
);

  always_comb begin
    cyc_addr = tgt;
    cyc_data = '0;
    cyc_last = 1'b0;
    case (op)
      OP_PROG: begin
        case (step)
          3'd0:    begin cyc_addr = UNLOCK_A1; cyc_data = DW'(CB_UNLOCK1); end
          3'd1:    begin cyc_addr = UNLOCK_A2; cyc_data = DW'(CB_UNLOCK2); end
          3'd2:    begin cyc_addr = UNLOCK_A1; cyc_data = DW'(CB_PROG); end
          default: begin cyc_data = data; cyc_last = 1'b1; end
        endcase
      end
      OP_ERASE: begin
        case (step)
          3'd0:    begin cyc_addr = UNLOCK_A1; cyc_data = DW'(CB_UNLOCK1); end
          3'd1:    begin cyc_addr = UNLOCK_A2; cyc_data = DW'(CB_UNLOCK2); end
          3'd2:    begin cyc_addr = UNLOCK_A1; cyc_data = DW'(CB_ERASE); end
          3'd3:    begin cyc_addr = UNLOCK_A1; cyc_data = DW'(CB_UNLOCK1); end
          3'd4:    begin cyc_addr = UNLOCK_A2; cyc_data = DW'(CB_UNLOCK2); end
          default: begin cyc_data = DW'(CB_SECTOR); cyc_last = 1'b1; end
        endcase
      end
      OP_SUSP: begin cyc_data = DW'(CB_SUSP);   cyc_last = 1'b1; end
      default: begin cyc_data = DW'(CB_SECTOR); cyc_last = 1'b1; end
    endcase
  end

endmodule

// File: rtl/nor_seq_status.sv
module nor_seq_status #(
  parameter int DW = 16,
  parameter int SB = 7
) (
  input  logic [DW-1:0] rdata,
  input  logic [DW-1:0] data,
  input  logic          match_data,
  output logic          conflict,
  output logic          hit
);

  // A 0 in the stored word cannot become 1 by programming
  function automatic logic needs_set(logic [DW-1:0] old_w, logic [DW-1:0] new_w);
    return |(~old_w & new_w);
  endfunction

  function automatic logic status_ok(logic [DW-1:0] rd, logic [DW-1:0] want, logic cmp);
    return cmp ? (rd[SB] == want[SB]) : rd[SB];
  endfunction

  assign conflict = needs_set(rdata, data);
  assign hit      = status_ok(rdata, data, match_data);

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int AW = 11,
  parameter int DW = 16,
  parameter logic [AW-1:0] UNLOCK_A1 = 'h555,
  parameter logic [AW-1:0] UNLOCK_A2 = 'h2AA
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_code,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_data,
  output logic          busy,
  output logic          done,
  output logic          reject,
  output logic [1:0]    state_o,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_wdata,
  output logic          fl_we,
  output logic          fl_re,
  input  logic [DW-1:0] fl_rdata
);

  localparam int STW = 3;
  localparam int SB  = 7;

  ph_e             phase;
  md_e             md;
  op_e             op_q;
  logic [AW-1:0]   tgt_q;
  logic [DW-1:0]   dat_q;
  logic [STW-1:0]  step_q;
  logic            bg_pend;
  logic            done_q;
  logic            rej_q;

  // Named events used by the FSM and by the assertions
  op_e             req_op;
  logic            req_take;
  logic            req_legal;
  logic            bg_rd;
  logic            bg_hit;
  logic            seq_last;
  logic            prog_conflict;
  logic            poll_hit;
  logic [AW-1:0]   cyc_addr;
  logic [DW-1:0]   cyc_data;

  assign req_op    = op_e'(op_code);
  assign busy      = (phase != PH_IDLE) || bg_pend;
  assign req_take  = op_valid && !busy;
  assign req_legal = op_allowed(req_op, md);
  assign bg_rd     = (phase == PH_IDLE) && (md == MD_ERASE) && !bg_pend && !req_take;
  assign bg_hit    = bg_pend && fl_rdata[SB];

  nor_seq_cmdgen #(
    .AW(AW), .DW(DW), .STW(STW), .UNLOCK_A1(UNLOCK_A1), .UNLOCK_A2(UNLOCK_A2)
  ) u_cmdgen (
    .op(op_q), .step(step_q), .tgt(tgt_q), .data(dat_q),
    .cyc_addr(cyc_addr), .cyc_data(cyc_data), .cyc_last(seq_last)
  );

  nor_seq_status #(.DW(DW), .SB(SB)) u_status (
    .rdata(fl_rdata), .data(dat_q), .match_data(op_q == OP_PROG),
    .conflict(prog_conflict), .hit(poll_hit)
  );

  assign fl_we    = (phase == PH_CMD);
  assign fl_re    = (phase == PH_PRE_RD) || (phase == PH_POLL_RD) || bg_rd;
  assign fl_addr  = fl_we ? cyc_addr : tgt_q;
  assign fl_wdata = fl_we ? cyc_data : '0;
  assign done     = done_q;
  assign reject   = rej_q;
  assign state_o  = md;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      md      <= MD_READ;
      op_q    <= OP_PROG;
      tgt_q   <= '0;
      dat_q   <= '0;
      step_q  <= '0;
      bg_pend <= 1'b0;
      done_q  <= 1'b0;
      rej_q   <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      rej_q   <= 1'b0;
      bg_pend <= bg_rd;
      case (phase)
        PH_IDLE: begin
          if (req_take) begin
            if (!req_legal) begin
              rej_q <= 1'b1;
            end else begin
              op_q   <= req_op;
              tgt_q  <= op_addr;
              dat_q  <= op_data;
              step_q <= '0;
              case (req_op)
                OP_PROG, OP_SUSP: phase <= PH_PRE_RD;
                OP_ERASE: begin phase <= PH_CMD; md <= MD_ERASE; end
                default:  phase <= PH_CMD;
              endcase
            end
          end else if (bg_hit) begin
            md     <= MD_READ;
            done_q <= 1'b1;
          end
        end
        PH_PRE_RD: phase <= PH_PRE_EV;
        PH_PRE_EV: begin
          if (op_q == OP_PROG) begin
            if (prog_conflict) begin
              rej_q <= 1'b1;
              phase <= PH_IDLE;
            end else begin
              md    <= MD_WRITE;
              phase <= PH_CMD;
            end
          end else if (fl_rdata[SB]) begin
            md     <= MD_READ;
            done_q <= 1'b1;
            phase  <= PH_IDLE;
          end else begin
            phase <= PH_CMD;
          end
        end
        PH_CMD: begin
          step_q <= step_q + 1'b1;
          if (seq_last) begin
            step_q <= '0;
            case (op_q)
              OP_PROG, OP_SUSP: phase <= PH_POLL_RD;
              OP_ERASE:         phase <= PH_IDLE;
              default: begin phase <= PH_IDLE; md <= MD_ERASE; end
            endcase
          end
        end
        PH_POLL_RD: phase <= PH_POLL_EV;
        PH_POLL_EV: begin
          if (poll_hit) begin
            done_q <= 1'b1;
            phase  <= PH_IDLE;
            md     <= (op_q == OP_PROG) ? MD_READ : MD_ESUSP;
          end else begin
            phase <= PH_POLL_RD;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R11: write cycles occur only inside a busy sequence
  p_we_in_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    fl_we |-> busy);

  // R2: program command cycles run in write mode
  p_prog_write_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && op_q == OP_PROG) |-> md == MD_WRITE);

  // R10: a reject follows no write and leaves the mode as it was
  p_reject_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rej_q |-> (!$past(fl_we) && md == $past(md)));

  // R8: the suspended mode is entered only from erase, with a done pulse
  p_susp_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (md == MD_ESUSP && $past(md) != MD_ESUSP) |-> ($past(md) == MD_ERASE && done_q));

  // R6: leaving erase for read always reports done
  p_erase_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (md == MD_READ && $past(md) == MD_ERASE) |-> done_q);

  // R4: done and reject never coincide
  p_done_xor_rej_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && rej_q));

  // R11: the bus never reads and writes in the same cycle
  p_bus_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(fl_we && fl_re));

endmodule

// File: tb/nor_cmd_seq_tb.sv
`timescale 1ns/1ps
module nor_cmd_seq_tb_top;

  localparam int AW = 11;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          op_valid = 1'b0;
  logic [1:0]    op_code = '0;
  logic [AW-1:0] op_addr = '0;
  logic [DW-1:0] op_data = '0;
  logic          busy, done, reject;
  logic [1:0]    state_o;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_wdata;
  logic          fl_we, fl_re;
  logic [DW-1:0] fl_rdata = '0;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  nor_cmd_seq #(.AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .op_addr(op_addr), .op_data(op_data), .busy(busy), .done(done),
    .reject(reject), .state_o(state_o), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata)
  );

  // Flash model: scripted read words, recorded write cycles
  logic [DW-1:0] rsp [0:15];
  logic          restart = 1'b0;
  int            rd_idx = 0;
  int            wcnt = 0;
  logic [AW-1:0] wa [0:15];
  logic [DW-1:0] wd [0:15];

  always @(posedge clk) begin
    if (restart) begin
      rd_idx <= 0;
      wcnt   <= 0;
    end else begin
      if (fl_re) begin
        fl_rdata <= rsp[rd_idx];
        if (rd_idx < 15) rd_idx <= rd_idx + 1;
      end
      if (fl_we) begin
        if (wcnt < 16) begin
          wa[wcnt] <= fl_addr;
          wd[wcnt] <= fl_wdata;
        end
        wcnt <= wcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic fill(input logic [DW-1:0] first, input int n_first, input logic [DW-1:0] rest);
    for (int k = 0; k < 16; k++) rsp[k] = (k < n_first) ? first : rest;
  endtask

  // Expected write cycle i of an operation; target -1 means the request address
  function automatic void exp_wr(input int op, input int i, input int a, input int d,
                                 output int ea, output int ed);
    int pa [0:3] = '{'h555, 'h2AA, 'h555, -1};
    int pd [0:3] = '{'hAA, 'h55, 'hA0, -1};
    int xa [0:5] = '{'h555, 'h2AA, 'h555, 'h555, 'h2AA, -1};
    int xd [0:5] = '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'h30};
    if (op == 0) begin
      ea = (pa[i] < 0) ? a : pa[i];
      ed = (pd[i] < 0) ? d : pd[i];
    end else if (op == 1) begin
      ea = (xa[i] < 0) ? a : xa[i];
      ed = xd[i];
    end else begin
      ea = a;
      ed = (op == 2) ? 'hB0 : 'h30;
    end
  endfunction

  task automatic chk_writes(input int op, input int a, input int d, input int n, input string req);
    chk(wcnt == n, req, wcnt, n);
    for (int i = 0; i < n && i < wcnt; i++) begin
      int ea, ed;
      exp_wr(op, i, a, d, ea, ed);
      chk(int'(wa[i]) == ea, req, int'(wa[i]), ea);
      chk(int'(wd[i]) == ed, req, int'(wd[i]), ed);
    end
  endtask

  int        t_done, t_rej;
  logic [1:0] st_h [0:63];
  logic       busy_h [0:63];

  // Present one request when the block is free; cycle 0 is the acceptance edge.
  // intr_n > 0 presents an erase request in that cycle (while busy).
  task automatic go(input int op, input int a, input int d, input int maxc, input int intr_n);
    @(negedge clk);
    while (busy) @(negedge clk);
    op_valid = 1'b1; op_code = 2'(op); op_addr = AW'(a); op_data = DW'(d);
    restart = 1'b1;
    t_done = 0; t_rej = 0;
    for (int n = 1; n <= maxc && n < 64; n++) begin
      @(negedge clk);
      if (n == 1) begin op_valid = 1'b0; restart = 1'b0; end
      if (intr_n != 0 && n == intr_n) begin op_valid = 1'b1; op_code = 2'd1; end
      if (intr_n != 0 && n == intr_n + 1) op_valid = 1'b0;
      st_h[n] = state_o;
      busy_h[n] = busy;
      if (done && t_done == 0) t_done = n;
      if (reject && t_rej == 0) t_rej = n;
      if (t_done != 0 || t_rej != 0) break;
    end
    op_valid = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    fill('0, 16, '0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(state_o == 2'd0, "R1 state", state_o, 0);
    chk(!busy && !done && !reject, "R1 flags", {busy, done, reject}, 0);
    chk(!fl_we && !fl_re, "R1 bus", {fl_we, fl_re}, 0);
    rst_n = 1'b1;

    // R10: suspend and resume refused in read mode
    for (int op = 2; op <= 3; op++) begin
      go(op, 'h100, 0, 8, 0);
      chk(t_rej == 1, "R10 read-mode reject cycle", t_rej, 1);
      chk(t_done == 0, "R10 no done", t_done, 0);
      chk(wcnt == 0, "R10 no writes", wcnt, 0);
      chk(state_o == 2'd0, "R10 mode kept", state_o, 0);
    end

    // Program sweep over all nibble pairs (old, new)
    for (int o = 0; o < 16; o++) begin
      for (int nn = 0; nn < 16; nn++) begin
        logic [15:0] oldw, neww;
        int p, a;
        oldw = {4{4'(o)}};
        neww = {4{4'(nn)}};
        p = 1 + ((o + nn) % 3);
        a = ((o * 16 + nn) * 7) % 2048;
        rsp[0] = oldw;
        for (int k = 1; k < 16; k++) rsp[k] = (k < p) ? (neww ^ 16'h0080) : neww;
        go(0, a, neww, 40, 0);
        if ((~oldw & neww) == 16'h0) begin
          chk(t_done == 7 + 2 * p, "R4 program done cycle", t_done, 7 + 2 * p);
          chk(t_rej == 0, "R3 legal program not rejected", t_rej, 0);
          chk(busy_h[1] == 1'b1, "R11 busy during program", busy_h[1], 1);
          chk(st_h[3] == 2'd1, "R2 write mode", st_h[3], 1);
          chk_writes(0, a, neww, 4, "R2 program cycles");
          @(negedge clk);
          chk(state_o == 2'd0, "R4 back to read", state_o, 0);
        end else begin
          chk(t_rej == 3, "R3 conflict reject cycle", t_rej, 3);
          chk(wcnt == 0, "R3 no writes", wcnt, 0);
          chk(state_o == 2'd0, "R3 mode read", state_o, 0);
        end
      end
    end

    // R11: a request while busy is ignored
    rsp[0] = 16'h00FF;
    for (int k = 1; k < 16; k++) rsp[k] = (k < 2) ? 16'h0000 : 16'h0081;
    go(0, 'h077, 'h0081, 40, 2);
    chk(t_rej == 0, "R11 ignored request no reject", t_rej, 0);
    chk(t_done == 11, "R11 program done cycle", t_done, 11);
    chk_writes(0, 'h077, 'h0081, 4, "R11 no extra writes");
    @(negedge clk);
    chk(state_o == 2'd0, "R11 mode read", state_o, 0);

    // Erase with background completion after P reads
    for (int p = 1; p <= 3; p++) begin
      fill(16'h0000, p - 1, 16'h0080);
      go(1, p * 256, 0, 40, 0);
      chk(st_h[1] == 2'd2, "R5 erase mode", st_h[1], 2);
      chk(t_done == 7 + 2 * p, "R6 erase done cycle", t_done, 7 + 2 * p);
      chk_writes(1, p * 256, 0, 6, "R5 erase cycles");
      @(negedge clk);
      chk(state_o == 2'd0, "R6 back to read", state_o, 0);
    end

    // Suspend / resume round trips with P reads each
    for (int p = 1; p <= 3; p++) begin
      int sec;
      sec = 'h300 + p * 16;
      fill('0, 16, '0);
      go(1, sec, 0, 12, 0);
      chk(t_done == 0, "R5 pending erase no done", t_done, 0);
      chk(state_o == 2'd2, "R5 erase pending", state_o, 2);
      for (int op = 0; op <= 3; op++) begin
        if (op != 2) begin
          go(op, 'h040, 0, 6, 0);
          chk(t_rej == 1, "R10 erase-mode reject", t_rej, 1);
          chk(wcnt == 0, "R10 no writes in erase", wcnt, 0);
          chk(state_o == 2'd2, "R10 erase kept", state_o, 2);
        end
      end
      fill(16'h0000, p, 16'h0080);
      go(2, sec, 0, 40, 0);
      chk(t_done == 4 + 2 * p, "R8 suspend done cycle", t_done, 4 + 2 * p);
      chk_writes(2, sec, 0, 1, "R8 suspend cycle");
      @(negedge clk);
      chk(state_o == 2'd3, "R8 suspended", state_o, 3);
      for (int op = 0; op <= 2; op++) begin
        go(op, 'h040, 0, 6, 0);
        chk(t_rej == 1, "R10 suspended reject", t_rej, 1);
        chk(wcnt == 0, "R10 no writes suspended", wcnt, 0);
        chk(state_o == 2'd3, "R10 suspended kept", state_o, 3);
      end
      fill(16'h0000, p - 1, 16'h0080);
      go(3, sec, 0, 40, 0);
      chk(t_done == 2 + 2 * p, "R9 resumed erase done cycle", t_done, 2 + 2 * p);
      if (p > 1) chk(st_h[2] == 2'd2, "R9 erase mode again", st_h[2], 2);
      chk_writes(3, sec, 0, 1, "R9 resume cycle");
      @(negedge clk);
      chk(state_o == 2'd0, "R9 finished to read", state_o, 0);
    end

    // R7: suspend finds erase already finished
    fill('0, 16, '0);
    go(1, 'h500, 0, 12, 0);
    fill(16'h0080, 16, 16'h0080);
    go(2, 'h500, 0, 20, 0);
    chk(t_done == 3, "R7 finished-erase suspend done cycle", t_done, 3);
    chk(wcnt == 0, "R7 no suspend write", wcnt, 0);
    @(negedge clk);
    chk(state_o == 2'd0, "R7 mode read", state_o, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule